// File: doc/BRIEF.md
# Fast Blank Video Soft Mixer

This block blends two digital video streams one pixel per clock. Stream A is the digitised analog RGB/YUV path and stream B is the digital YUV path. Each pixel is a triplet of 8-bit components. A 6-bit fast blank sample arrives alongside the video. It is turned into a blend coefficient between 0 and 32 by a programmable offset and gain centred on 16. That coefficient then weights B against A for all three components of the pixel.

Configuration inputs set several things. One inverts the fast blank polarity. One forces the fast blank value to a fixed mid level. One shifts the fast blank sample in time against the video by between one clock early and two clocks late; a late shift against a black background makes characters cast a shadow. Two more inputs pick a plain pass-through of either stream in place of the blend. The output is registered and comes two clocks after the input pixel, with a valid strobe that travels with it.

Top module: `fb_soft_mixer`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_pix` are 0.
- R2: `out_valid` equals `in_valid` from two clock edges earlier. The pixel given with a valid input appears on `out_pix` two edges later.
- R3: With polarity and clamp off, the coefficient is c = floor((fb − offset) × gain / 2) + 16, limited to 0..32. Here fb is the sample used, offset is an unsigned 6-bit value and gain is an unsigned 4-bit value. The result is rounded toward negative infinity.
- R4: In blend mode each component is (A × (32 − c) + B × c + 16) / 32, using integer division. Components sit at bits [7:0], [15:8] and [23:16] of the pixel buses.
- R5: When `cfg_fb_invert` is 1, the fast blank value 63 − fb_in is used in place of fb_in.
- R6: When `cfg_fb_clamp` is 1, the value 31 is used in place of the fast blank value, whether or not inversion is on. The coefficient then depends only on offset and gain.
- R7: `cfg_fb_delay` code k (0..3) delays the fast blank by k − 1 clocks relative to the video. A pixel taken in at edge t is blended with the `fb_in` taken in at edge t + 1 − k. Code 0 means the fast blank leads by one clock, and code 3 means it lags by two.
- R8: When `cfg_pass_rgb` is 0, the output pixel is stream A unchanged, whatever the other controls are.
- R9: When `cfg_pass_rgb` is 1 and `cfg_pass_yuv` is 1, the output pixel is stream B unchanged.
- R10: When `cfg_pass_rgb` is 1 and `cfg_pass_yuv` is 0, the output is the blend of R4.
- R11: When no valid pixel reaches the output stage, `out_pix` keeps its last value. A pixel offered with `in_valid` low does not reach the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel qualifier |
| a_pix | input | 24 | Stream A pixel, three 8-bit components |
| b_pix | input | 24 | Stream B pixel, three 8-bit components |
| fb_in | input | 6 | Fast blank sample, 0..63 |
| cfg_fb_invert | input | 1 | Use 63 − fb_in |
| cfg_fb_clamp | input | 1 | Use 31 as the fast blank value |
| cfg_fb_offset | input | 6 | Coefficient offset |
| cfg_mix_gain | input | 4 | Coefficient gain |
| cfg_fb_delay | input | 2 | Fast blank timing code, gives k − 1 clocks |
| cfg_pass_rgb | input | 1 | 0 forces stream A through |
| cfg_pass_yuv | input | 1 | With cfg_pass_rgb = 1, forces stream B through |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 24 | Output pixel |

## Verification
The hardest case to reach is the timing relation of R7. A wrong tap only shows when the fast blank changes every clock and the gain is high enough that neighbouring samples give different coefficients. The stimulus therefore drives a fresh random fast blank value on every clock, with gain 15 and offset 31, under each of the four delay codes. It also opens random gaps in `in_valid`, so that the hold behaviour is exercised while the fast blank history keeps moving. Sweeps of every fast blank value across extreme offsets and gains reach both saturation limits and odd negative products, where floor rounding differs from truncation.

// File: rtl/fbmix_pkg.sv
package fbmix_pkg;

  // Timing code for the fast blank path relative to the video path
  typedef enum logic [1:0] {
    FBD_LEAD1 = 2'd0,
    FBD_ALIGN = 2'd1,
    FBD_LAG1  = 2'd2,
    FBD_LAG2  = 2'd3
  } fb_dly_e;

  // Output source chosen by the pass-through controls
  typedef enum logic [1:0] {
    SRC_A   = 2'd0,
    SRC_B   = 2'd1,
    SRC_MIX = 2'd2
  } src_sel_e;

  function automatic src_sel_e pick_source(input logic pass_rgb, input logic pass_yuv);
    if (!pass_rgb)     return SRC_A;
    else if (pass_yuv) return SRC_B;
    else               return SRC_MIX;
  endfunction

endpackage

// File: rtl/fbmix_delay_line.sv
module fbmix_delay_line #(
  parameter int W     = 6,
  parameter int DEPTH = 3,
  localparam int SW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] sel,
  output logic [W-1:0]  dout
);

  logic [W-1:0] tap [DEPTH+1];

  assign tap[0] = din;

  for (genvar i = 1; i <= DEPTH; i++) begin : g_stage
    logic [W-1:0] stage_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= tap[i-1];
    end
    assign tap[i] = stage_q;
  end

  always_comb begin
    dout = tap[0];
    for (int j = 0; j <= DEPTH; j++) begin
      if (SW'(j) == sel) dout = tap[j];
    end
  end

endmodule

// File: rtl/fbmix_coef.sv
module fbmix_coef #(
  parameter int FB_W   = 6,
  parameter int OFS_W  = 6,
  parameter int GAIN_W = 4,
  parameter int FRAC   = 5
) (
  input  logic [FB_W-1:0]   fb,
  input  logic              invert,
  input  logic              clamp,
  input  logic [OFS_W-1:0]  offset,
  input  logic [GAIN_W-1:0] gain,
  output logic [FRAC:0]     coef
);

  localparam int FB_MAX  = (1 << FB_W) - 1;
  localparam int FB_MIDV = FB_MAX / 2;
  localparam int UNITY   = 1 << FRAC;
  localparam int CENTRE  = UNITY / 2;
  localparam int DW      = ((FB_W > OFS_W) ? FB_W : OFS_W) + 2;
  localparam int PW      = DW + GAIN_W + 2;

  logic [FB_W-1:0]        fb_pol;
  logic [FB_W-1:0]        fb_eff;
  logic signed [DW-1:0]   diff;
  logic signed [PW-1:0]   prod;
  logic signed [PW-1:0]   biased;

  always_comb begin
    fb_pol = invert ? (FB_W'(FB_MAX) - fb) : fb;
    fb_eff = clamp ? FB_W'(FB_MIDV) : fb_pol;
    diff   = signed'(DW'(fb_eff)) - signed'(DW'(offset));
    prod   = PW'(diff) * signed'(PW'(gain));
    biased = (prod >>> 1) + signed'(PW'(CENTRE));
    if (biased < 0)                           coef = '0;
    else if (biased > signed'(PW'(UNITY)))    coef = (FRAC+1)'(UNITY);
    else                                      coef = biased[FRAC:0];
  end

endmodule

// File: rtl/fbmix_blend.sv
module fbmix_blend #(
  parameter int CW    = 8,
  parameter int NCOMP = 3,
  parameter int FRAC  = 5,
  localparam int PW   = CW * NCOMP
) (
  input  logic [PW-1:0] a,
  input  logic [PW-1:0] b,
  input  logic [FRAC:0] coef,
  output logic [PW-1:0] y
);

  localparam int UNITY = 1 << FRAC;
  localparam int AW    = CW + FRAC + 2;

  logic [AW-1:0] wa;
  logic [AW-1:0] wb;

  assign wb = AW'(coef);
  assign wa = AW'(UNITY) - wb;

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    logic [AW-1:0] acc;
    assign acc = AW'(a[c*CW +: CW]) * wa + AW'(b[c*CW +: CW]) * wb + AW'(UNITY / 2);
    assign y[c*CW +: CW] = acc[FRAC +: CW];
  end

endmodule

// File: rtl/fb_soft_mixer.sv
module fb_soft_mixer #(
  parameter int CW      = 8,
  parameter int NCOMP   = 3,
  parameter int FB_W    = 6,
  parameter int OFS_W   = 6,
  parameter int GAIN_W  = 4,
  parameter int FRAC    = 5,
  parameter int FB_XTRA = 3,
  localparam int PW     = CW * NCOMP,
  localparam int DSW    = $clog2(FB_XTRA + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PW-1:0]     a_pix,
  input  logic [PW-1:0]     b_pix,
  input  logic [FB_W-1:0]   fb_in,
  input  logic              cfg_fb_invert,
  input  logic              cfg_fb_clamp,
  input  logic [OFS_W-1:0]  cfg_fb_offset,
  input  logic [GAIN_W-1:0] cfg_mix_gain,
  input  logic [DSW-1:0]    cfg_fb_delay,
  input  logic              cfg_pass_rgb,
  input  logic              cfg_pass_yuv,
  output logic              out_valid,
  output logic [PW-1:0]     out_pix
);

  import fbmix_pkg::*;

  // Stage 1: video capture
  logic          v1_valid_q, v1_valid_d;
  logic [PW-1:0] a_q, a_d;
  logic [PW-1:0] b_q, b_d;

  // Fast blank path
  logic [FB_W-1:0] fb_sel;
  logic [FRAC:0]   coef_w;

  // Stage 2: output
  logic [PW-1:0] mix_pix;
  logic [PW-1:0] src_pix;
  src_sel_e      src;
  logic          out_valid_d;
  logic [PW-1:0] out_pix_d;

  fbmix_delay_line #(
    .W     (FB_W),
    .DEPTH (FB_XTRA)
  ) fb_dly_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (fb_in),
    .sel   (cfg_fb_delay),
    .dout  (fb_sel)
  );

  fbmix_coef #(
    .FB_W   (FB_W),
    .OFS_W  (OFS_W),
    .GAIN_W (GAIN_W),
    .FRAC   (FRAC)
  ) coef_i (
    .fb     (fb_sel),
    .invert (cfg_fb_invert),
    .clamp  (cfg_fb_clamp),
    .offset (cfg_fb_offset),
    .gain   (cfg_mix_gain),
    .coef   (coef_w)
  );

  fbmix_blend #(
    .CW    (CW),
    .NCOMP (NCOMP),
    .FRAC  (FRAC)
  ) blend_i (
    .a    (a_q),
    .b    (b_q),
    .coef (coef_w),
    .y    (mix_pix)
  );

  // Next-state logic
  always_comb begin
    v1_valid_d = in_valid;
    a_d        = in_valid ? a_pix : a_q;
    b_d        = in_valid ? b_pix : b_q;
  end

  always_comb begin
    src = pick_source(cfg_pass_rgb, cfg_pass_yuv);
    unique case (src)
      SRC_A:   src_pix = a_q;
      SRC_B:   src_pix = b_q;
      default: src_pix = mix_pix;
    endcase
    out_valid_d = v1_valid_q;
    out_pix_d   = v1_valid_q ? src_pix : out_pix;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_valid_q <= 1'b0;
      a_q        <= '0;
      b_q        <= '0;
    end else begin
      v1_valid_q <= v1_valid_d;
      a_q        <= a_d;
      b_q        <= b_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= out_valid_d;
      out_pix   <= out_pix_d;
    end
  end

endmodule

// File: rtl/fb_soft_mixer_chk.sv
module fb_soft_mixer_chk #(
  parameter int PW     = 24,
  parameter int OFS_W  = 6,
  parameter int GAIN_W = 4,
  parameter int FRAC   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              cfg_fb_clamp,
  input logic [OFS_W-1:0]  cfg_fb_offset,
  input logic [GAIN_W-1:0] cfg_mix_gain,
  input logic              cfg_pass_rgb,
  input logic              cfg_pass_yuv,
  input logic              v1_valid_q,
  input logic [PW-1:0]     a_q,
  input logic [PW-1:0]     b_q,
  input logic [FRAC:0]     coef_w,
  input logic              out_valid,
  input logic [PW-1:0]     out_pix
);

  localparam int UNITY = 1 << FRAC;

  logic [1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             seen <= '0;
    else if (seen != 2'd3)  seen <= seen + 2'd1;
  end

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 2'd2) |-> (out_valid == $past(in_valid, 2)));                      // R2

  AST_COEF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 2'd1) |-> (coef_w <= (FRAC+1)'(UNITY)));                           // R3

  AST_CLAMP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 2'd1 && cfg_fb_clamp && $past(cfg_fb_clamp) &&
     $stable(cfg_fb_offset) && $stable(cfg_mix_gain)) |-> $stable(coef_w));     // R6

  AST_RGB_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_valid_q && !cfg_pass_rgb) |=> (out_pix == $past(a_q)));                 // R8

  AST_YUV_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_valid_q && cfg_pass_rgb && cfg_pass_yuv) |=> (out_pix == $past(b_q)));  // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!v1_valid_q) |=> $stable(out_pix));                                        // R11

endmodule

bind fb_soft_mixer fb_soft_mixer_chk #(
  .PW     (PW),
  .OFS_W  (OFS_W),
  .GAIN_W (GAIN_W),
  .FRAC   (FRAC)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .cfg_fb_clamp  (cfg_fb_clamp),
  .cfg_fb_offset (cfg_fb_offset),
  .cfg_mix_gain  (cfg_mix_gain),
  .cfg_pass_rgb  (cfg_pass_rgb),
  .cfg_pass_yuv  (cfg_pass_yuv),
  .v1_valid_q    (v1_valid_q),
  .a_q           (a_q),
  .b_q           (b_q),
  .coef_w        (coef_w),
  .out_valid     (out_valid),
  .out_pix       (out_pix)
);

// File: tb/fb_soft_mixer_tb_top.sv
module fb_soft_mixer_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] a_pix = '0;
  logic [23:0] b_pix = '0;
  logic [5:0]  fb_in = '0;
  logic        cfg_fb_invert = 1'b0;
  logic        cfg_fb_clamp = 1'b0;
  logic [5:0]  cfg_fb_offset = '0;
  logic [3:0]  cfg_mix_gain = '0;
  logic [1:0]  cfg_fb_delay = 2'd1;
  logic        cfg_pass_rgb = 1'b0;
  logic        cfg_pass_yuv = 1'b0;
  logic        out_valid;
  logic [23:0] out_pix;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_soft_mixer dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .a_pix         (a_pix),
    .b_pix         (b_pix),
    .fb_in         (fb_in),
    .cfg_fb_invert (cfg_fb_invert),
    .cfg_fb_clamp  (cfg_fb_clamp),
    .cfg_fb_offset (cfg_fb_offset),
    .cfg_mix_gain  (cfg_mix_gain),
    .cfg_fb_delay  (cfg_fb_delay),
    .cfg_pass_rgb  (cfg_pass_rgb),
    .cfg_pass_yuv  (cfg_pass_yuv),
    .out_valid     (out_valid),
    .out_pix       (out_pix)
  );

  int    n_cmp  = 0;
  int    n_bad  = 0;
  bit    chk_en = 1'b0;
  bit    done   = 1'b0;
  string phase_tag = "R10";

  // Behavioural reference model
  int    fb_hist [3];
  bit    m_v1;
  int    m_a [3];
  int    m_b [3];
  bit    exp_valid;
  int    exp_c [3];
  string exp_tag = "R1";

  function automatic int ref_coef(int fb, bit inv, bit clp, int ofs, int g);
    int f, t, h, c;
    f = inv ? (63 - fb) : fb;
    if (clp) f = 31;
    t = (f - ofs) * g;
    h = (t >= 0) ? (t / 2) : -((1 - t) / 2);
    c = h + 16;
    if (c < 0)  c = 0;
    if (c > 32) c = 32;
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        fb_hist[i] = 0; m_a[i] = 0; m_b[i] = 0; exp_c[i] = 0;
      end
      m_v1 = 0; exp_valid = 0; exp_tag = "R1";
    end else begin
      int sel_fb, c;
      sel_fb = (cfg_fb_delay == 0) ? int'(fb_in) : fb_hist[cfg_fb_delay - 1];
      c = ref_coef(sel_fb, cfg_fb_invert, cfg_fb_clamp, cfg_fb_offset, cfg_mix_gain);
      exp_valid = m_v1;
      if (m_v1) begin
        for (int i = 0; i < 3; i++) begin
          if (!cfg_pass_rgb)     exp_c[i] = m_a[i];
          else if (cfg_pass_yuv) exp_c[i] = m_b[i];
          else                   exp_c[i] = (m_a[i] * (32 - c) + m_b[i] * c + 16) / 32;
        end
        if (!cfg_pass_rgb)     exp_tag = "R8";
        else if (cfg_pass_yuv) exp_tag = "R9";
        else                   exp_tag = phase_tag;
      end else begin
        exp_tag = "R11";
      end
      fb_hist[2] = fb_hist[1];
      fb_hist[1] = fb_hist[0];
      fb_hist[0] = fb_in;
      m_v1 = in_valid;
      if (in_valid) begin
        for (int i = 0; i < 3; i++) begin
          m_a[i] = a_pix[i*8 +: 8];
          m_b[i] = b_pix[i*8 +: 8];
        end
      end
    end
  end

  // Comparison away from the active edge
  always @(negedge clk) begin
    if (chk_en && !done) begin
      logic [23:0] e_pix;
      for (int i = 0; i < 3; i++) e_pix[i*8 +: 8] = 8'(exp_c[i]);
      n_cmp++;
      if (out_valid !== exp_valid) begin
        n_bad++;
        $display("FAIL %s out_valid actual=%0b expected=%0b at %0t",
                 rst_n ? "R2" : "R1", out_valid, exp_valid, $time);
      end else if (out_pix !== e_pix) begin
        n_bad++;
        $display("FAIL %s out_pix actual=%06h expected=%06h at %0t",
                 rst_n ? exp_tag : "R1", out_pix, e_pix, $time);
      end
    end
  end

  task automatic drive(bit v, int fb);
    @(negedge clk);
    in_valid = v;
    a_pix    = $urandom;
    b_pix    = $urandom;
    fb_in    = 6'(fb);
  endtask

  task automatic set_cfg(bit rgb, bit yuv, bit inv, bit clp, int ofs, int g, int dly);
    @(negedge clk);
    cfg_pass_rgb  = rgb;
    cfg_pass_yuv  = yuv;
    cfg_fb_invert = inv;
    cfg_fb_clamp  = clp;
    cfg_fb_offset = 6'(ofs);
    cfg_mix_gain  = 4'(g);
    cfg_fb_delay  = 2'(dly);
  endtask

  task automatic flush();
    repeat (4) drive(1'b0, 0);
  endtask

  initial begin
    int gains [5] = '{0, 1, 2, 7, 15};
    int offs  [3] = '{0, 31, 63};
    // R1: reset state observed over several edges
    repeat (2) @(posedge clk);
    chk_en = 1'b1;
    repeat (3) drive(1'b1, 5);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: stream A forced through, R2 timing covered throughout
    set_cfg(0, 1, 0, 0, 10, 15, 1);
    repeat (40) drive(1'b1, $urandom_range(63));
    // R9: stream B forced through
    set_cfg(1, 1, 1, 0, 0, 15, 2);
    repeat (40) drive(1'b1, $urandom_range(63));
    flush();

    // R3 / R4 / R10: sweep every fast blank value over gains and offsets
    phase_tag = "R3";
    foreach (gains[gi]) begin
      foreach (offs[oi]) begin
        set_cfg(1, 0, 0, 0, offs[oi], gains[gi], 1);
        for (int f = 0; f < 64; f++) drive(1'b1, f);
      end
    end
    phase_tag = "R4";
    set_cfg(1, 0, 0, 0, 20, 3, 1);
    repeat (80) drive(1'b1, $urandom_range(63));
    flush();

    // R5: inverted polarity
    phase_tag = "R5";
    set_cfg(1, 0, 1, 0, 17, 5, 1);
    for (int f = 0; f < 64; f++) drive(1'b1, f);
    flush();

    // R6: clamp, with and without inversion
    phase_tag = "R6";
    set_cfg(1, 0, 0, 1, 25, 9, 1);
    repeat (40) drive(1'b1, $urandom_range(63));
    set_cfg(1, 0, 1, 1, 40, 6, 2);
    repeat (40) drive(1'b1, $urandom_range(63));
    flush();

    // R7: every delay code with a fast blank changing each clock
    phase_tag = "R7";
    for (int d = 0; d < 4; d++) begin
      set_cfg(1, 0, 0, 0, 31, 15, d);
      repeat (60) drive(1'b1, $urandom_range(63));
    end
    flush();

    // R11: random gaps in the input qualifier, mixed modes
    phase_tag = "R11";
    for (int d = 0; d < 4; d++) begin
      set_cfg(1, 0, 0, 0, 28, 11, d);
      repeat (60) drive(1'($urandom_range(1)), $urandom_range(63));
    end
    set_cfg(0, 0, 0, 0, 28, 11, 1);
    repeat (30) drive(1'($urandom_range(1)), $urandom_range(63));
    flush();

    // R1: reset again in the middle of traffic
    drive(1'b1, 9);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) drive(1'b1, 9);
    @(negedge clk);
    rst_n = 1'b1;
    flush();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule